// File: doc/BRIEF.md
# Split-Screen Line Reorderer

This block takes a full-width video line that arrives two adjacent pixels per clock and turns it into two separate streams. One stream carries the left half of the screen and the other carries the right half. Each output stream also carries two pixels per clock. With the default parameters a line is 3840 pixels wide, so it arrives in 1920 input beats. Each half-screen stream is 1920 pixels wide, which is 960 pair beats. Frames are 2400 lines tall, but frame height needs no logic here.

Storage is one line in total, split into two half-line banks of pair words. Bank A takes the left half of each incoming line and bank B takes the right half. While the left half of line n+1 is written into bank A, both banks are read at the same address as that write. Bank A returns its old word on that collision, so every such beat emits one left pair and one right pair of line n. Output therefore lags input by one line. Both streams are idle while bank B is being refilled during the second half of each input line.

A controller state machine sequences the two banks. Its states are:
- `ST_WAIT_SOF`: waits for a frame start.
- `ST_PRIME_L` and `ST_PRIME_R`: fill the banks from the first line, with no output.
- `ST_RUN_L`: writes bank A and reads both banks.
- `ST_RUN_R`: writes bank B only.

Its transitions are:
- Half-wrap: when the beat pointer reaches its last value, the machine steps PRIME_L→PRIME_R→RUN_L→RUN_R→RUN_L.
- Restart: any frame-start beat, and any line-start beat that is not the first beat of a left half, jumps to PRIME_L. That beat is then taken as beat 0 of the left half.

Top module: `splitline_reorder`

## Requirements
- R1: Each pair word carries the earlier pixel in bits [PIX_W-1:0] and the later pixel in bits [2*PIX_W-1:PIX_W], on input and on both outputs.
- R2: During line n+1, output beat k carries input beat k of line n on `left_pair` and input beat HALF+k of line n on `right_pair` (HALF = LINE_PIX/4, 960 by default).
- R3: The output for input beat k (k < HALF) of a line appears in the clock cycle after that beat is accepted.
- R4: `left_valid` and `right_valid` are asserted only for input beats 0..HALF-1 of a line. They stay low for beats HALF..2*HALF-1.
- R5: The line that begins with a frame-start beat produces no output, and nor does the first line after reset.
- R6: When bank A is read and rewritten at the same address in the same cycle, the read returns the word of the previous line.
- R7: `out_sol` is high on output beat 0 of every output line. `out_sof` is high only on output beat 0 of the first output line after a frame start, and never without `out_sol`.
- R8: A line-start beat that does not fall on beat 0 of a left half discards the buffered line and restarts filling, taking that beat as beat 0. The line that begins there produces no output.
- R9: After reset, beats are ignored until a frame-start beat arrives, and no output is produced.
- R10: Cycles with `in_valid` low produce no output and do not advance the line position.
- R11: During reset, and just after it, both valid outputs and both markers are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair beat present |
| in_sof | input | 1 | Beat is the first of a frame |
| in_sol | input | 1 | Beat is the first of a line |
| in_pair | input | 2*PIX_W | Two adjacent input pixels |
| left_valid | output | 1 | Left stream pair present |
| left_pair | output | 2*PIX_W | Left-half pixel pair |
| right_valid | output | 1 | Right stream pair present |
| right_pair | output | 2*PIX_W | Right-half pixel pair |
| out_sol | output | 1 | First pair of an output line |
| out_sof | output | 1 | First pair of the first output line of a frame |

## Verification
The bench runs full-width lines in which every pixel value encodes its line number and its position. A design that reads bank A after the write, instead of before, would emit the current line's left half in place of the previous one. A wrong pointer wrap would shift or mix pixels across the half boundary, and both show up as data mismatches. Idle gaps inside a line catch a pointer that advances without a beat. A truncated line that ends in a misplaced line-start checks that stale data is dropped rather than streamed. Frame starts in the middle of the stream check that the priming line stays silent and that the frame marker lands on exactly one beat.

// File: rtl/splitline_pkg.sv
package splitline_pkg;

    // Controller sequence: wait for a frame, prime both banks, then alternate.
    typedef enum logic [2:0] {
        ST_WAIT_SOF,
        ST_PRIME_L,
        ST_PRIME_R,
        ST_RUN_L,
        ST_RUN_R
    } split_state_e;

endpackage

// File: rtl/line_half_ram.sv
module line_half_ram #(
    parameter int DEPTH = 960,
    parameter int WIDTH = 48,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read samples the array before this edge's write lands: old data on collision.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
    import splitline_pkg::*;
#(
    parameter int HALF = 960,
    localparam int AW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    output logic          wr_a,
    output logic          wr_b,
    output logic          rd,
    output logic [AW-1:0] addr,
    output logic          emit_sol,
    output logic          emit_sof
);

    localparam logic [AW-1:0] LAST = AW'(HALF - 1);

    split_state_e  st_q, st_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic          sofp_q, sofp_d;

    logic left_st, right_st, sol_aligned, restart, advance;

    always_comb begin
        left_st     = (st_q == ST_PRIME_L) || (st_q == ST_RUN_L);
        right_st    = (st_q == ST_PRIME_R) || (st_q == ST_RUN_R);
        sol_aligned = left_st && (ptr_q == '0);
        restart     = in_valid && (in_sof ||
                      (in_sol && (st_q != ST_WAIT_SOF) && !sol_aligned));
        advance     = in_valid && (st_q != ST_WAIT_SOF) && !restart;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_WAIT_SOF;
            ptr_q  <= '0;
            sofp_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ptr_q  <= ptr_d;
            sofp_q <= sofp_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        ptr_d  = ptr_q;
        sofp_d = sofp_q;
        if (restart) begin
            st_d   = ST_PRIME_L;
            ptr_d  = AW'(1);
            sofp_d = in_sof;
        end else if (advance) begin
            if (st_q == ST_RUN_L && ptr_q == '0) begin
                sofp_d = 1'b0;
            end
            if (ptr_q == LAST) begin
                ptr_d = '0;
                unique case (st_q)
                    ST_PRIME_L: st_d = ST_PRIME_R;
                    ST_PRIME_R: st_d = ST_RUN_L;
                    ST_RUN_L:   st_d = ST_RUN_R;
                    ST_RUN_R:   st_d = ST_RUN_L;
                    default:    st_d = st_q;
                endcase
            end else begin
                ptr_d = ptr_q + AW'(1);
            end
        end
    end

    // Output decode
    always_comb begin
        wr_a     = restart || (advance && left_st);
        wr_b     = advance && right_st;
        rd       = advance && (st_q == ST_RUN_L);
        addr     = restart ? '0 : ptr_q;
        emit_sol = rd && (ptr_q == '0);
        emit_sof = emit_sol && sofp_q;
    end

    // R2: a beat lands in exactly one bank
    p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_a && wr_b));

    // R6: every read beat rewrites bank A at the same address
    p_read_rewrites_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> wr_a);

    // R4: no reads while the right half is being filled
    p_right_half_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        right_st |-> !rd);

    // R9: before a frame start nothing is written or read
    p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_SOF && !(in_valid && in_sof)) |-> !(wr_a || wr_b || rd));

endmodule

// File: rtl/splitline_reorder.sv
module splitline_reorder #(
    parameter int PIX_W    = 24,
    parameter int LINE_PIX = 3840,
    localparam int PAIR_W  = 2 * PIX_W,
    localparam int BEATS   = LINE_PIX / 2,
    localparam int HALF    = BEATS / 2,
    localparam int AW      = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PAIR_W-1:0] in_pair,
    output logic              left_valid,
    output logic [PAIR_W-1:0] left_pair,
    output logic              right_valid,
    output logic [PAIR_W-1:0] right_pair,
    output logic              out_sol,
    output logic              out_sof
);

    logic          wr_a, wr_b, rd, emit_sol, emit_sof;
    logic [AW-1:0] addr;
    logic [1:0]    bank_we;
    logic [PAIR_W-1:0] bank_q [2];

    split_ctrl #(.HALF(HALF)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .rd       (rd),
        .addr     (addr),
        .emit_sol (emit_sol),
        .emit_sof (emit_sof)
    );

    assign bank_we = {wr_b, wr_a};

    // Bank 0 holds left halves, bank 1 right halves
    for (genvar g = 0; g < 2; g++) begin : g_bank
        line_half_ram #(.DEPTH(HALF), .WIDTH(PAIR_W)) u_ram (
            .clk     (clk),
            .wr_en   (bank_we[g]),
            .wr_addr (addr),
            .wr_data (in_pair),
            .rd_en   (rd),
            .rd_addr (addr),
            .rd_data (bank_q[g])
        );
    end

    logic valid_q, sol_q, sof_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sol_q   <= 1'b0;
            sof_q   <= 1'b0;
        end else begin
            valid_q <= rd;
            sol_q   <= emit_sol;
            sof_q   <= emit_sof;
        end
    end

    assign left_valid  = valid_q;
    assign right_valid = valid_q;
    assign left_pair   = bank_q[0];
    assign right_pair  = bank_q[1];
    assign out_sol     = sol_q;
    assign out_sof     = sof_q;

    // R5: a frame-start beat never yields an output beat
    p_sof_beat_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !left_valid);

    // R10: an idle input cycle yields no output
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!left_valid && !right_valid));

    // R7: markers only ride on valid beats, frame marker only with line marker
    p_sol_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> (left_valid && right_valid));
    p_sof_on_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol);

endmodule

// File: tb/splitline_reorder_test.sv
module splitline_reorder_test;

    localparam int PIX_W    = 24;
    localparam int LINE_PIX = 3840;
    localparam int PAIR_W   = 2 * PIX_W;
    localparam int BEATS    = LINE_PIX / 2;
    localparam int HALF_B   = BEATS / 2;

    // Line table: [15] frame start, [14] idle gaps, [13] output expected,
    // [12] frame marker expected on output, [11:0] beats sent (0 = full line)
    localparam logic [15:0] LINES [0:8] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 12'd0},
        {1'b0, 1'b0, 1'b1, 1'b1, 12'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 12'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 12'd0},
        {1'b1, 1'b0, 1'b0, 1'b0, 12'd0},
        {1'b0, 1'b0, 1'b1, 1'b1, 12'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 12'(HALF_B + 3)},
        {1'b0, 1'b0, 1'b0, 1'b0, 12'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 12'd0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_sof, in_sol;
    logic [PAIR_W-1:0] in_pair;
    logic left_valid, right_valid, out_sol, out_sof;
    logic [PAIR_W-1:0] left_pair, right_pair;

    always #10 clk = ~clk;

    splitline_reorder #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sof      (in_sof),
        .in_sol      (in_sol),
        .in_pair     (in_pair),
        .left_valid  (left_valid),
        .left_pair   (left_pair),
        .right_valid (right_valid),
        .right_pair  (right_pair),
        .out_sol     (out_sol),
        .out_sof     (out_sof)
    );

    int checks = 0;
    int errors = 0;

    logic              p_v = 1'b0, p_sol = 1'b0, p_sof = 1'b0;
    logic [PAIR_W-1:0] p_l = '0, p_r = '0;
    string             p_req = "R11";

    function automatic logic [PIX_W-1:0] pix(input int tag, input int idx);
        return {8'(tag), 16'(idx)};
    endfunction

    // R1: earlier pixel in the low half of the pair word
    function automatic logic [PAIR_W-1:0] pair_of(input int tag, input int beat);
        return {pix(tag, 2 * beat + 1), pix(tag, 2 * beat)};
    endfunction

    task automatic check_out();
        checks++;
        if (left_valid !== p_v || right_valid !== p_v) begin
            errors++;
            $display("FAIL %s valid: left %b right %b expected %b", p_req,
                     left_valid, right_valid, p_v);
        end
        if (p_v) begin
            checks++;
            if (left_pair !== p_l) begin
                errors++;
                $display("FAIL R1 R6 left pair: got %h expected %h", left_pair, p_l);
            end
            checks++;
            if (right_pair !== p_r) begin
                errors++;
                $display("FAIL R1 R2 right pair: got %h expected %h", right_pair, p_r);
            end
        end
        checks++;
        if (out_sol !== p_sol || out_sof !== p_sof) begin
            errors++;
            $display("FAIL R7 markers: sol %b sof %b expected %b %b",
                     out_sol, out_sof, p_sol, p_sof);
        end
    endtask

    // One cycle: check the result of the previous beat, then drive the next (R3)
    task automatic step(input logic v, input logic sof, input logic sol,
                        input logic [PAIR_W-1:0] d, input logic ev, input logic esol,
                        input logic esof, input logic [PAIR_W-1:0] el,
                        input logic [PAIR_W-1:0] er, input string req);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_sof   = sof;
        in_sol   = sol;
        in_pair  = d;
        p_v   = ev;
        p_sol = esol;
        p_sof = esof;
        p_l   = el;
        p_r   = er;
        p_req = req;
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, req);
    endtask

    task automatic send_line(input int tag, input logic [15:0] cfg);
        int n;
        n = (cfg[11:0] == 0) ? BEATS : int'(cfg[11:0]);
        for (int k = 0; k < n; k++) begin
            logic ev;
            string req;
            if (cfg[14] && (k % 7 == 3)) begin
                idle("R10");
            end
            ev = cfg[13] && (k < HALF_B);
            if (ev)            req = "R3";
            else if (cfg[13])  req = "R4";
            else if (cfg[15])  req = "R5";
            else               req = "R8";
            step(1'b1, cfg[15] && (k == 0), k == 0, pair_of(tag, k),
                 ev, ev && (k == 0), ev && (k == 0) && cfg[12],
                 pair_of(tag - 1, k), pair_of(tag - 1, HALF_B + k), req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_sol   = 1'b0;
        in_pair  = '0;
        repeat (3) @(negedge clk);
        // R11: outputs low in reset
        check_out();
        rst_n = 1'b1;
        idle("R11");
        idle("R11");

        // R9: a full line with line markers but no frame start is ignored
        for (int k = 0; k < BEATS; k++) begin
            step(1'b1, 1'b0, k == 0, pair_of(200, k), 1'b0, 1'b0, 1'b0, '0, '0, "R9");
        end
        idle("R9");

        // Table walk: priming, streaming, gaps, new frame, misplaced line start (R8)
        for (int e = 0; e < 9; e++) begin
            send_line(e, LINES[e]);
        end
        idle("R4");
        idle("R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule